// File: doc/BRIEF.md
# Parking Bus Arbiter with Overlapped Selection

This block decides which of several masters owns a shared bus. Every master has a request line, a release line and a grant line. The arbiter keeps exactly one owner, or none at all, and moves ownership only when the current owner lets go. An owner keeps the bus for as many back-to-back cycles as its block transfer needs. It gives the bus up by pulsing its release line.

While a transaction runs, the arbiter keeps choosing the next owner and holds the choice in a register. A release can then hand the bus to that master on the very next edge, with no dead cycle.

When nobody else wants the bus after a release, the grant stays parked on the last owner. That owner can start another transaction without arbitrating again. The selection rule is fixed priority, with master 0 first. A per-master count of lost handoffs promotes a waiting master above the fixed order once the count passes a limit set on an input. This keeps low-priority masters from being starved.

Top module: `bus_arbiter_park`

## Requirements
- R1: After reset, no grant is asserted and `busy_o` is low. With no owner and no request, the arbiter stays that way.
- R2: With no owner, any request produces a grant to the winner on the next clock edge, and `busy_o` rises at the same edge.
- R3: Without promotion, the winner is the requesting master with the lowest index.
- R4: `gnt_o` has at most one bit set in every cycle, including cycles where a release and new requests coincide.
- R5: While `busy_o` is high, the grant cannot change until the owner pulses its own release bit. Release bits from masters that do not own the bus have no effect.
- R6: Suppose the owner releases while a precomputed contender exists, that is, another master was requesting in an earlier busy cycle of this transaction. Then the grant moves to that contender at the next edge, and `busy_o` stays high.
- R7: A release with no precomputed contender parks the bus: the grant is held and `busy_o` falls. If the parked owner then requests and nobody else does, `busy_o` rises again with the grant unchanged.
- R8: When the bus is parked and any other master requests, the grant moves to the winner among the other requesters at the next edge, and `busy_o` rises. This holds even if the parked owner also requests.
- R9: Each handoff counts as one round. At each round, every requesting master that loses has its wait count incremented, saturating at its all-ones value. The winner's count is cleared. A master whose count is greater than `promote_after_i` is promoted. Among promoted requesters the lowest index wins, and any promoted requester beats every non-promoted one.
- R10: A request that first appears in the same cycle as the owner's release is not part of the precomputed choice. The bus parks for one cycle and then moves to that requester under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| promote_after_i | input | AGE_W | Lost-round limit above which a waiting master is promoted |
| req_i | input | NUM_MASTERS | Per-master bus request |
| rel_i | input | NUM_MASTERS | Per-master release pulse, honoured only from the owner |
| gnt_o | output | NUM_MASTERS | One-hot grant, all zero when idle |
| busy_o | output | 1 | Owner is inside a transaction (low when idle or parked) |

## Verification
The bench targets several corner cases that a faulty arbiter would get wrong:
- A release from a non-owner: a bad design would drop or steal the bus.
- A release issued in the grant's first cycle: a design with a stale precomputed winner would hand the bus back to the master that just received it.
- A request that arrives exactly in the release cycle: a design without a registered choice would skip the parked cycle.
- A master starved behind two high-priority masters: it must win once its wait count passes each tried limit, and a design with a wrong comparison or a wrong counter clear would make it wait too long or too little.

Long mixed traffic across several limits also checks that the grant never shows two owners and never goes dark once the bus has been granted.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_BUSY = 2'd1,
      BUS_PARK = 2'd2
   } bus_phase_e;

endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] cand_i,
   input  logic [WIDTH-1:0] urgent_i,
   output logic [WIDTH-1:0] win_o,
   output logic             any_o
);
   logic [WIDTH-1:0] urg_cand;
   logic [WIDTH-1:0] pool;

   always_comb begin
      urg_cand = cand_i & urgent_i;
      pool     = (urg_cand != '0) ? urg_cand : cand_i;
      win_o    = pool & (~pool + {{(WIDTH-1){1'b0}}, 1'b1});
      any_o    = (cand_i != '0);
   end
endmodule

// File: rtl/arb_age.sv
module arb_age #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned AGE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             round_i,
   input  logic [WIDTH-1:0] req_i,
   input  logic [WIDTH-1:0] win_i,
   input  logic [AGE_W-1:0] limit_i,
   output logic [WIDTH-1:0] urgent_o
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   for (genvar m = 0; m < WIDTH; m++) begin : g_cnt
      logic [AGE_W-1:0] age_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q <= '0;
         end else if (round_i) begin
            if (win_i[m])
               age_q <= '0;
            else if (req_i[m] && age_q != AGE_MAX)
               age_q <= age_q + 1'b1;
         end
      end

      assign urgent_o[m] = (age_q > limit_i);
   end
endmodule

// File: rtl/bus_arbiter_park.sv
module bus_arbiter_park
   import arb_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 4,
   parameter int unsigned AGE_W       = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AGE_W-1:0]       promote_after_i,
   input  logic [NUM_MASTERS-1:0] req_i,
   input  logic [NUM_MASTERS-1:0] rel_i,
   output logic [NUM_MASTERS-1:0] gnt_o,
   output logic                   busy_o
);
   localparam int unsigned N = NUM_MASTERS;

   if (NUM_MASTERS < 2) begin : g_bad_masters
      $error("bus_arbiter_park: NUM_MASTERS must be at least 2");
   end
   if (AGE_W < 1) begin : g_bad_age
      $error("bus_arbiter_park: AGE_W must be at least 1");
   end

   logic [N-1:0] own_q, nxt_q;
   logic         busy_q, nxt_v_q;
   logic [N-1:0] others, win_c, urgent, round_win;
   logic         any_c, rel_own, own_req, round;
   bus_phase_e   phase;

   always_comb begin
      others  = req_i & ~own_q;
      rel_own = |(rel_i & own_q);
      own_req = |(req_i & own_q);
      if (own_q == '0)
         phase = BUS_IDLE;
      else if (busy_q)
         phase = BUS_BUSY;
      else
         phase = BUS_PARK;
   end

   arb_pick #(.WIDTH(N)) i_pick (
      .cand_i   (others),
      .urgent_i (urgent),
      .win_o    (win_c),
      .any_o    (any_c)
   );

   always_comb begin
      round     = 1'b0;
      round_win = win_c;
      unique case (phase)
         BUS_IDLE: round = any_c;
         BUS_PARK: round = any_c;
         BUS_BUSY: begin
            round     = rel_own && nxt_v_q;
            round_win = nxt_q;
         end
         default: round = 1'b0;
      endcase
   end

   arb_age #(.WIDTH(N), .AGE_W(AGE_W)) i_age (
      .clk      (clk),
      .rst_n    (rst_n),
      .round_i  (round),
      .req_i    (req_i),
      .win_i    (round_win),
      .limit_i  (promote_after_i),
      .urgent_o (urgent)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q   <= '0;
         busy_q  <= 1'b0;
         nxt_q   <= '0;
         nxt_v_q <= 1'b0;
      end else begin
         unique case (phase)
            BUS_IDLE: begin
               if (any_c) begin
                  own_q  <= win_c;
                  busy_q <= 1'b1;
               end
               nxt_v_q <= 1'b0;
            end
            BUS_BUSY: begin
               if (rel_own) begin
                  if (nxt_v_q)
                     own_q <= nxt_q;
                  else
                     busy_q <= 1'b0;
                  nxt_v_q <= 1'b0;
               end else begin
                  nxt_q   <= win_c;
                  nxt_v_q <= any_c;
               end
            end
            BUS_PARK: begin
               if (any_c) begin
                  own_q  <= win_c;
                  busy_q <= 1'b1;
               end else if (own_req) begin
                  busy_q <= 1'b1;
               end
               nxt_v_q <= 1'b0;
            end
            default: begin
               own_q   <= '0;
               busy_q  <= 1'b0;
               nxt_v_q <= 1'b0;
            end
         endcase
      end
   end

   assign gnt_o  = own_q;
   assign busy_o = busy_q;
endmodule

// File: rtl/bus_arbiter_park_chk.sv
module bus_arbiter_park_chk #(
   parameter int unsigned NUM_MASTERS = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_MASTERS-1:0] req_i,
   input logic [NUM_MASTERS-1:0] rel_i,
   input logic [NUM_MASTERS-1:0] gnt_o,
   input logic                   busy_o
);
   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   p_idle_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0 && busy_o));

   p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (rel_i & gnt_o) == '0) |=> (gnt_o == $past(gnt_o) && busy_o));

   p_never_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0) |=> (gnt_o != '0));

   p_park_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && gnt_o != '0 && req_i == '0) |=> ($stable(gnt_o) && !busy_o));

   p_idle_no_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o == '0) |-> !busy_o);
endmodule

bind bus_arbiter_park bus_arbiter_park_chk #(.NUM_MASTERS(NUM_MASTERS)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req_i  (req_i),
   .rel_i  (rel_i),
   .gnt_o  (gnt_o),
   .busy_o (busy_o)
);

// File: tb/test_bus_arbiter_park.sv
module test_bus_arbiter_park;
   localparam int CLK_PERIOD = 10;
   localparam int NM   = 4;
   localparam int AW   = 4;
   localparam int AMAX = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] limit = '0;
   logic [NM-1:0] req = '0;
   logic [NM-1:0] rel = '0;
   logic [NM-1:0] gnt;
   logic          busy;

   int n_tests = 0;
   int n_fails = 0;

   int m_own;
   bit m_busy;
   int m_nxt;
   bit m_nv;
   int m_age [NM];
   int unsigned seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_arbiter_park #(.NUM_MASTERS(NM), .AGE_W(AW)) i_bus_arbiter_park (
      .clk             (clk),
      .rst_n           (rst_n),
      .promote_after_i (limit),
      .req_i           (req),
      .rel_i           (rel),
      .gnt_o           (gnt),
      .busy_o          (busy)
   );

   function automatic int pick(input logic [NM-1:0] mask);
      for (int i = 0; i < NM; i++)
         if (mask[i] && m_age[i] > int'(limit)) return i;
      for (int i = 0; i < NM; i++)
         if (mask[i]) return i;
      return -1;
   endfunction

   task automatic hand(input int w, input logic [NM-1:0] r);
      for (int i = 0; i < NM; i++) begin
         if (i == w) m_age[i] = 0;
         else if (r[i] && m_age[i] < AMAX) m_age[i] = m_age[i] + 1;
      end
      m_own = w;
      m_nv  = 1'b0;
   endtask

   task automatic model_step(input logic [NM-1:0] r, input logic [NM-1:0] l);
      logic [NM-1:0] oth;
      oth = r;
      if (m_own >= 0) oth[m_own] = 1'b0;
      if (m_own < 0) begin
         if (r != '0) begin
            hand(pick(oth), r);
            m_busy = 1'b1;
         end
      end else if (m_busy) begin
         if (l[m_own]) begin
            if (m_nv) hand(m_nxt, r);
            else m_busy = 1'b0;
            m_nv = 1'b0;
         end else if (oth != '0) begin
            m_nxt = pick(oth);
            m_nv  = 1'b1;
         end else begin
            m_nv = 1'b0;
         end
      end else begin
         if (oth != '0) begin
            hand(pick(oth), r);
            m_busy = 1'b1;
         end else if (r[m_own]) begin
            m_busy = 1'b1;
         end
      end
   endtask

   function automatic logic [NM-1:0] exp_gnt();
      return (m_own < 0) ? '0 : (NM'(1) << m_own);
   endfunction

   task automatic check(input string tag);
      n_tests++;
      if (gnt !== exp_gnt() || busy !== m_busy) begin
         n_fails++;
         $display("FAIL %s: gnt=%b busy=%b expected gnt=%b busy=%b",
                  tag, gnt, busy, exp_gnt(), m_busy);
      end
      n_tests++;
      if (!$onehot0(gnt)) begin
         n_fails++;
         $display("FAIL R4: gnt=%b expected at most one bit", gnt);
      end
   endtask

   task automatic step(input logic [NM-1:0] r, input logic [NM-1:0] l, input string tag);
      @(negedge clk);
      req = r;
      rel = l;
      @(posedge clk);
      model_step(r, l);
      #1;
      check(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req = '0;
      rel = '0;
      m_own = -1; m_busy = 1'b0; m_nxt = -1; m_nv = 1'b0;
      for (int i = 0; i < NM; i++) m_age[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset");
   endtask

   function automatic int unsigned rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
   end

   initial begin
      logic [NM-1:0] hold;
      limit = 4'd3;
      do_reset();
      step(4'b0000, 4'b0000, "R1 idle stays idle");
      step(4'b0000, 4'b0000, "R1 idle stays idle");

      step(4'b1010, 4'b0000, "R2/R3 idle grant to lowest");
      step(4'b1000, 4'b1001, "R5 foreign release ignored");
      step(4'b1000, 4'b0000, "R5 hold during block");
      step(4'b1000, 4'b0010, "R6 handoff after release");
      step(4'b0000, 4'b0000, "R6 new owner busy");
      step(4'b0000, 4'b1000, "R7 park on release");
      step(4'b0000, 4'b0000, "R7 parked quiet");
      step(4'b1000, 4'b0000, "R7 parked owner resumes");
      step(4'b0000, 4'b1000, "R7 park again");
      step(4'b1001, 4'b0000, "R8 parked handoff");
      step(4'b0000, 4'b0000, "R5 hold");
      step(4'b0100, 4'b0001, "R10 request in release cycle parks");
      step(4'b0100, 4'b0000, "R10 then moves");
      step(4'b0011, 4'b0100, "R10 release in first cycle of grant parks");
      step(4'b0011, 4'b0000, "R8 parked handoff to lowest");

      limit = 4'd1;
      do_reset();
      step(4'b1011, 4'b0000, "R9 start");
      for (int k = 0; k < 12; k++) begin
         step(4'b1011, 4'b0000, "R9 contend");
         step(4'b1011, exp_gnt(), "R9 rotate by age");
      end

      for (int lim = 0; lim < 4; lim++) begin
         limit = AW'(lim);
         do_reset();
         hold = '0;
         for (int c = 0; c < 3000; c++) begin
            logic [NM-1:0] r, l;
            int unsigned v;
            for (int i = 0; i < NM; i++) begin
               v = rnd();
               if (i == m_own) hold[i] = 1'b0;
               else if (!hold[i] && (v % 4) == 0) hold[i] = 1'b1;
            end
            r = hold;
            l = '0;
            v = rnd();
            if (m_own >= 0) begin
               r[m_own] = v[0] & v[1];
               l[m_own] = (v[4:2] == 3'd0);
            end
            if (v[9:7] == 3'd0) l[v[11:10]] = 1'b1;
            step(r, l, "R9 sweep");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
   end
endmodule